// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block produces the start, restart and stop conditions on an open-drain two-wire bus for a serial interface that runs in a simple I2C mode. Software sets a request bit for each kind of condition. The block then plays out the matching waveform on its own SDA and SCL levels, one step per programmable half bit period. When a waveform ends, the block clears the request and sets a sticky completion flag. That flag, combined with an interrupt enable, drives an interrupt output.

Each line has a 2-bit output-select field. It decides whether the line follows the serial data path, follows the condition generator, is held low or is released. A condition is started only while both fields select the generator. Lines are modelled as open-drain pull-down enables: an enable of 1 pulls the line low, and 0 releases it.

Top module: `i2c_cond_gen`

## Requirements
- R1: A synchronous active-high reset clears all three request bits and the completion flag, sets both generator levels to released, and forces `sdaOe` and `sclOe` to 0 while reset is high.
- R2: Each line's select field picks its pull-down enable in the same cycle: 00 follows the inverse of the serial path bit, 01 follows the inverse of the generator level, 10 gives 1 (pull low) and 11 gives 0 (released).
- R3: A write pulse sets its request bit on the next edge. A pending request leaves the generator levels untouched until the block is idle and both select fields read 01. The condition launches on that edge.
- R4: A start condition is one step in which SDA is low and SCL is high.
- R5: A restart condition is three steps: SDA released with SCL low, then both released, then SDA low with SCL released.
- R6: A stop condition is two steps: SDA low with SCL released, then both released.
- R7: Each step lasts H clock cycles, where H is `halfPeriod`. The levels of step 0 appear on the edge that launches the condition. The request bit clears and the completion flag sets together, H × steps edges after the launch edge. A write to a request bit on that same edge keeps the bit set.
- R8: When several requests are pending, start is served before restart, and restart before stop. Only one condition runs at a time, and the next one can launch on the edge after completion.
- R9: The completion flag clears on any edge where `flagClrWr` is 1, `i2cModeEn` is 0 or `txEn` is 0. A clear takes priority over a completion on the same edge.
- R10: `irq` is 1 exactly while the completion flag is 1 and `teIntEn` is 1.
- R11: A `halfPeriod` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halfPeriod | input | CNT_W | Clock cycles per waveform step |
| startWr | input | 1 | Write 1 to the start request bit |
| restartWr | input | 1 | Write 1 to the restart request bit |
| stopWr | input | 1 | Write 1 to the stop request bit |
| flagClrWr | input | 1 | Write 0 to the completion flag |
| i2cModeEn | input | 1 | I2C mode enable; 0 clears the flag |
| txEn | input | 1 | Transmit enable; 0 clears the flag |
| teIntEn | input | 1 | Interrupt enable for the completion flag |
| sdaSel | input | 2 | SDA output select |
| sclSel | input | 2 | SCL output select |
| shiftSda | input | 1 | SDA level from the serial data path |
| shiftScl | input | 1 | SCL level from the serial data path |
| sdaOe | output | 1 | SDA pull-down enable |
| sclOe | output | 1 | SCL pull-down enable |
| startReq | output | 1 | Start request bit |
| restartReq | output | 1 | Restart request bit |
| stopReq | output | 1 | Stop request bit |
| doneFlag | output | 1 | Completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The pull-down enables and `irq` are combinational from the select fields, the path bits, the enable and the registered state, so they reflect an input change in the same cycle. The request bits, the flag and the generator levels are registered. A write or clear appears one edge later. Step levels change every H edges, and completion lands H × steps edges after the launch edge. The bench drives inputs at the falling edge and advances its reference model on the rising edge. It compares all outputs at the next falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [1:0] {
    COND_START   = 2'd0,
    COND_RESTART = 2'd1,
    COND_STOP    = 2'd2
  } condKind_e;

  localparam logic [1:0] SEL_SHIFT = 2'b00;
  localparam logic [1:0] SEL_GEN   = 2'b01;
  localparam logic [1:0] SEL_LOW   = 2'b10;
  localparam logic [1:0] SEL_OPEN  = 2'b11;

  // control-to-datapath strobes
  typedef struct packed {
    logic      load;
    condKind_e kind;
    logic [1:0] step;
  } genStrobe_t;

  // returns {scl, sda}; 1 = released
  function automatic logic [1:0] stepLevels(condKind_e k, logic [1:0] s);
    logic [1:0] lv;
    lv = 2'b11;
    case (k)
      COND_START:   lv = 2'b10;
      COND_RESTART: lv = (s == 2'd0) ? 2'b01 : (s == 2'd1) ? 2'b11 : 2'b10;
      COND_STOP:    lv = (s == 2'd0) ? 2'b10 : 2'b11;
      default:      lv = 2'b11;
    endcase
    return lv;
  endfunction

  function automatic logic [1:0] lastStep(condKind_e k);
    logic [1:0] n;
    case (k)
      COND_RESTART: n = 2'd2;
      COND_STOP:    n = 2'd1;
      default:      n = 2'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] halfPeriod,
  input  logic             startWr,
  input  logic             restartWr,
  input  logic             stopWr,
  input  logic             flagClrWr,
  input  logic             i2cModeEn,
  input  logic             txEn,
  input  logic             selOk,
  output logic [2:0]       reqVec,
  output logic             doneFlag,
  output logic             busy,
  output genStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  condKind_e        kind;
  condKind_e        pick;
  logic [1:0]       step;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effHalf;
  logic             stepEnd;
  logic             doneNow;
  logic             launch;
  logic [2:0]       doneMask;
  logic             flagClr;

  assign effHalf = (halfPeriod == '0) ? ONE : halfPeriod;
  assign stepEnd = busy && (cnt == effHalf - ONE);
  assign doneNow = stepEnd && (step == lastStep(kind));
  assign launch  = !busy && (reqVec != 3'b000) && selOk;
  assign flagClr = flagClrWr || !i2cModeEn || !txEn;

  always_comb begin
    if (reqVec[0])      pick = COND_START;
    else if (reqVec[1]) pick = COND_RESTART;
    else                pick = COND_STOP;
  end

  always_comb begin
    doneMask = 3'b000;
    if (doneNow) begin
      case (kind)
        COND_START:   doneMask = 3'b001;
        COND_RESTART: doneMask = 3'b010;
        default:      doneMask = 3'b100;
      endcase
    end
  end

  always_comb begin
    strobe.load = launch || (stepEnd && !doneNow);
    strobe.kind = launch ? pick : kind;
    strobe.step = launch ? 2'd0 : step + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqVec   <= 3'b000;
      doneFlag <= 1'b0;
      busy     <= 1'b0;
      kind     <= COND_START;
      step     <= 2'd0;
      cnt      <= '0;
    end else begin
      reqVec <= (reqVec & ~doneMask) | {stopWr, restartWr, startWr};
      if (flagClr)      doneFlag <= 1'b0;
      else if (doneNow) doneFlag <= 1'b1;
      if (launch) begin
        busy <= 1'b1;
        kind <= pick;
        step <= 2'd0;
        cnt  <= '0;
      end else if (busy) begin
        if (doneNow) begin
          busy <= 1'b0;
        end else if (stepEnd) begin
          step <= step + 2'd1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_cond_dp.sv
module i2c_cond_dp
  import i2c_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  genStrobe_t strobe,
  input  logic [1:0] sdaSel,
  input  logic [1:0] sclSel,
  input  logic       shiftSda,
  input  logic       shiftScl,
  output logic       sdaOe,
  output logic       sclOe,
  output logic       genSda,
  output logic       genScl
);

  localparam int LINES = 2;

  logic [LINES-1:0] lineOe;
  logic [1:0]       lineSel   [LINES];
  logic [LINES-1:0] shiftBit;
  logic [LINES-1:0] genBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      genSda <= 1'b1;
      genScl <= 1'b1;
    end else if (strobe.load) begin
      {genScl, genSda} <= stepLevels(strobe.kind, strobe.step);
    end
  end

  assign lineSel[0] = sdaSel;
  assign lineSel[1] = sclSel;
  assign shiftBit   = {shiftScl, shiftSda};
  assign genBit     = {genScl, genSda};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      case (lineSel[i])
        SEL_SHIFT: lineOe[i] = !shiftBit[i];
        SEL_GEN:   lineOe[i] = !genBit[i];
        SEL_LOW:   lineOe[i] = 1'b1;
        default:   lineOe[i] = 1'b0;
      endcase
      if (rst) lineOe[i] = 1'b0;
    end
  end

  assign sdaOe = lineOe[0];
  assign sclOe = lineOe[1];

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] halfPeriod,
  input  logic             startWr,
  input  logic             restartWr,
  input  logic             stopWr,
  input  logic             flagClrWr,
  input  logic             i2cModeEn,
  input  logic             txEn,
  input  logic             teIntEn,
  input  logic [1:0]       sdaSel,
  input  logic [1:0]       sclSel,
  input  logic             shiftSda,
  input  logic             shiftScl,
  output logic             sdaOe,
  output logic             sclOe,
  output logic             startReq,
  output logic             restartReq,
  output logic             stopReq,
  output logic             doneFlag,
  output logic             irq
);

  genStrobe_t strobe;
  logic [2:0] reqVec;
  logic       busy;
  logic       selOk;
  logic       genSda;
  logic       genScl;

  assign selOk = (sdaSel == SEL_GEN) && (sclSel == SEL_GEN);

  i2c_cond_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .halfPeriod(halfPeriod),
    .startWr(startWr), .restartWr(restartWr), .stopWr(stopWr),
    .flagClrWr(flagClrWr), .i2cModeEn(i2cModeEn), .txEn(txEn),
    .selOk(selOk), .reqVec(reqVec), .doneFlag(doneFlag),
    .busy(busy), .strobe(strobe)
  );

  i2c_cond_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .sdaSel(sdaSel), .sclSel(sclSel),
    .shiftSda(shiftSda), .shiftScl(shiftScl),
    .sdaOe(sdaOe), .sclOe(sclOe),
    .genSda(genSda), .genScl(genScl)
  );

  assign startReq   = reqVec[0];
  assign restartReq = reqVec[1];
  assign stopReq    = reqVec[2];
  assign irq        = doneFlag && teIntEn;

endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk (
  input logic       clk,
  input logic       rst,
  input logic       flagClrWr,
  input logic       i2cModeEn,
  input logic       txEn,
  input logic [1:0] sdaSel,
  input logic [1:0] sclSel,
  input logic       startReq,
  input logic       restartReq,
  input logic       stopReq,
  input logic       doneFlag,
  input logic       irq,
  input logic       busy,
  input logic       genSda,
  input logic       genScl
);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (flagClrWr || !i2cModeEn || !txEn) |=> !doneFlag);

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(doneFlag) |-> $past(busy));

  assert_gated_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(sdaSel == 2'b01 && sclSel == 2'b01)) |=> $stable({genSda, genScl}));

  assert_stop_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(stopReq) |-> (genSda && genScl));

  assert_single_done_R8: assert property (@(posedge clk) disable iff (rst)
    $countones({$fell(startReq), $fell(restartReq), $fell(stopReq)}) <= 1);

  assert_irq_flag_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> doneFlag);

endmodule

bind i2c_cond_gen i2c_cond_chk u_chk (
  .clk(clk), .rst(rst), .flagClrWr(flagClrWr), .i2cModeEn(i2cModeEn),
  .txEn(txEn), .sdaSel(sdaSel), .sclSel(sclSel), .startReq(startReq),
  .restartReq(restartReq), .stopReq(stopReq), .doneFlag(doneFlag),
  .irq(irq), .busy(busy), .genSda(genSda), .genScl(genScl)
);

// File: tb/tb_i2c_cond_gen.sv
module tb_i2c_cond_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] halfPeriod = 8'd2;
  logic       startWr = 0, restartWr = 0, stopWr = 0, flagClrWr = 0;
  logic       i2cModeEn = 1, txEn = 1, teIntEn = 0;
  logic [1:0] sdaSel = 2'b11, sclSel = 2'b11;
  logic       shiftSda = 1, shiftScl = 1;
  logic       sdaOe, sclOe, startReq, restartReq, stopReq, doneFlag, irq;

  int vecs = 0;
  int bad  = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  i2c_cond_gen dut (
    .clk(clk), .rst(rst), .halfPeriod(halfPeriod),
    .startWr(startWr), .restartWr(restartWr), .stopWr(stopWr),
    .flagClrWr(flagClrWr), .i2cModeEn(i2cModeEn), .txEn(txEn),
    .teIntEn(teIntEn), .sdaSel(sdaSel), .sclSel(sclSel),
    .shiftSda(shiftSda), .shiftScl(shiftScl),
    .sdaOe(sdaOe), .sclOe(sclOe), .startReq(startReq),
    .restartReq(restartReq), .stopReq(stopReq),
    .doneFlag(doneFlag), .irq(irq)
  );

  // reference model: levels are {scl,sda}, 1 = released; queue entries add bit2 = last
  int mReq[3];
  int mFlag = 0;
  int mLvl = 3;
  int mKind = 0;
  int lvlQ[$];

  function automatic int stepLv(int k, int s);
    if (k == 0) return 2;                       // R4
    if (k == 1) return (s == 0) ? 1 : (s == 1) ? 3 : 2;  // R5
    return (s == 0) ? 2 : 3;                    // R6
  endfunction

  function automatic int stepCnt(int k);
    return (k == 0) ? 1 : (k == 1) ? 3 : 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) mReq[i] = 0;
      mFlag = 0; mLvl = 3; lvlQ.delete();
    end else begin
      int lastNow;
      int wr[3];
      lastNow = 0;
      wr[0] = startWr; wr[1] = restartWr; wr[2] = stopWr;
      if (lvlQ.size() > 0) begin
        int e;
        e = lvlQ.pop_front();
        mLvl = e & 3;
        lastNow = (e >> 2) & 1;
      end else if ((mReq[0] + mReq[1] + mReq[2]) > 0 && sdaSel == 2'b01 && sclSel == 2'b01) begin
        int h, n;
        mKind = mReq[0] ? 0 : mReq[1] ? 1 : 2;   // R8 priority
        h = (halfPeriod == 0) ? 1 : int'(halfPeriod);  // R11
        n = stepCnt(mKind);
        mLvl = stepLv(mKind, 0);
        for (int j = 1; j <= n * h; j++) begin
          if (j < n * h) lvlQ.push_back(stepLv(mKind, j / h));
          else           lvlQ.push_back(stepLv(mKind, n - 1) | 4);
        end
      end
      for (int i = 0; i < 3; i++)
        mReq[i] = ((mReq[i] != 0 && !(lastNow != 0 && mKind == i)) || wr[i] != 0) ? 1 : 0;
      if (flagClrWr || !i2cModeEn || !txEn) mFlag = 0;
      else if (lastNow != 0) mFlag = 1;
    end
  end

  function automatic int lineOe(logic [1:0] sel, logic shiftBit, int genBit);
    if (rst) return 0;
    case (sel)
      2'b00: return shiftBit ? 0 : 1;
      2'b01: return genBit ? 0 : 1;
      2'b10: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic compare(string tag);
    int eSda, eScl, eIrq;
    eSda = lineOe(sdaSel, shiftSda, mLvl & 1);
    eScl = lineOe(sclSel, shiftScl, (mLvl >> 1) & 1);
    eIrq = (mFlag != 0 && teIntEn) ? 1 : 0;
    vecs++;
    if (int'(sdaOe) != eSda || int'(sclOe) != eScl ||
        int'(startReq) != mReq[0] || int'(restartReq) != mReq[1] || int'(stopReq) != mReq[2] ||
        int'(doneFlag) != mFlag || int'(irq) != eIrq) begin
      bad++;
      $display("FAIL %s t=%0t: lines R2 got %0d%0d exp %0d%0d | reqs R3 R7 got %0d%0d%0d exp %0d%0d%0d | flag R9 got %0d exp %0d | irq R10 got %0d exp %0d",
               tag, $time, sdaOe, sclOe, eSda, eScl, startReq, restartReq, stopReq,
               mReq[0], mReq[1], mReq[2], doneFlag, mFlag, irq, eIrq);
    end
  endtask

  task automatic cyc(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, got hung exp done");
    finishRun();
  end

  initial begin
    // R1: reset state
    cyc("R1", 3);
    rst = 0;
    cyc("R1", 2);

    // R2: select encodings on each line
    for (int s = 0; s < 4; s++) begin
      sdaSel = 2'(s); sclSel = 2'(3 - s);
      shiftSda = 0; shiftScl = 1; cyc("R2");
      shiftSda = 1; shiftScl = 0; cyc("R2");
    end

    // R3: pending start without both selects at 01
    sdaSel = 2'b01; sclSel = 2'b00;
    startWr = 1; cyc("R3"); startWr = 0;
    cyc("R3", 12);
    // R4, R7, R10: start with H=3
    halfPeriod = 8'd3; teIntEn = 1; sclSel = 2'b01;
    cyc("R4", 10);
    teIntEn = 0; cyc("R10", 2); teIntEn = 1; cyc("R10");

    // R9: clear by write, then restart with H=2 (R5)
    flagClrWr = 1; cyc("R9"); flagClrWr = 0;
    halfPeriod = 8'd2;
    restartWr = 1; cyc("R5"); restartWr = 0;
    cyc("R5", 10);

    // R6, R11: stop with H=0
    flagClrWr = 1; cyc("R9"); flagClrWr = 0;
    halfPeriod = 8'd0;
    stopWr = 1; cyc("R6"); stopWr = 0;
    cyc("R11", 6);

    // R8: all three at once
    halfPeriod = 8'd2;
    startWr = 1; restartWr = 1; stopWr = 1; cyc("R8"); 
    startWr = 0; restartWr = 0; stopWr = 0;
    cyc("R8", 20);

    // R9: clear sources held across a completion, clear wins
    txEn = 0; stopWr = 1; cyc("R9"); stopWr = 0;
    cyc("R9", 8); txEn = 1; cyc("R9", 2);
    i2cModeEn = 0; startWr = 1; cyc("R9"); startWr = 0;
    cyc("R9", 6); i2cModeEn = 1;
    flagClrWr = 1; restartWr = 1; cyc("R9"); restartWr = 0;
    cyc("R9", 12); flagClrWr = 0; cyc("R9", 2);

    // R7: write on the completion edge keeps request set
    halfPeriod = 8'd1;
    startWr = 1; cyc("R7", 3); startWr = 0; cyc("R7", 4);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      startWr   = ($urandom_range(0, 19) == 0);
      restartWr = ($urandom_range(0, 19) == 0);
      stopWr    = ($urandom_range(0, 19) == 0);
      flagClrWr = ($urandom_range(0, 9) == 0);
      i2cModeEn = ($urandom_range(0, 29) != 0);
      txEn      = ($urandom_range(0, 29) != 0);
      teIntEn   = 1'($urandom_range(0, 1));
      shiftSda  = 1'($urandom_range(0, 1));
      shiftScl  = 1'($urandom_range(0, 1));
      sdaSel    = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
      sclSel    = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
      if (lvlQ.size() == 0 && $urandom_range(0, 7) == 0) halfPeriod = 8'($urandom_range(0, 4));
      cyc("R8");
    end
    startWr = 0; restartWr = 0; stopWr = 0; flagClrWr = 0;
    cyc("R7", 20);

    // R1: reset mid-run
    sdaSel = 2'b01; sclSel = 2'b01; halfPeriod = 8'd3;
    stopWr = 1; cyc("R1"); stopWr = 0; cyc("R1", 2);
    rst = 1; cyc("R1", 2); rst = 0; cyc("R1", 3);

    finishRun();
  end

endmodule